// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

The block turns parallel characters into asynchronous serial frames on one output line. A character is written into a one-entry holding buffer. On a bit boundary it moves into a shift register that sends a start bit, then the data bits, then an optional parity bit, then the stop bits. While that frame is on the line, the next character can wait in the holding buffer. Two handshake outputs report the state of the two stages: one shows that the holding buffer is free, the other that the shift stage is idle.

Bit timing comes from a clock-enable input. A rate selector sets how many enable pulses make up one bit time. Character length, parity and stop-bit count are inputs, and they are sampled when a character moves into the shift stage. A transmit-enable input can stop new frames from starting without cutting off the frame that is already on the line.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is being sent, `txd_o` is 1, `tx_rdy_o` is 1 and `tx_empty_o` is 1.
- R2: A frame starts with one 0 bit. Then come N data bits, least significant bit first, where N = 5 + `len_sel_i` (0→5, 1→6, 2→7, 3→8). Character bits above N are not sent.
- R3: When `par_en_i` is 1, one parity bit follows the last data bit. If `par_odd_i` is 1, the data bits and the parity bit together hold an odd number of ones; if it is 0, they hold an even number. When `par_en_i` is 0, no parity bit is sent.
- R4: The frame ends with stop bits of value 1: two when `two_stop_i` is 1, one when it is 0.
- R5: One bit time is F pulses of `bit_en_i`, with `rate_sel_i` 0→F=1, 1→F=16, 2 or 3→F=64. Cycles with `bit_en_i` low do not advance the line.
- R6: `tx_rdy_o` goes low in the cycle after an accepted load. It goes high again on the same edge that moves the character into the shift stage, which is the edge where the start bit appears.
- R7: `tx_empty_o` goes low on the edge where a start bit appears from an idle line. It goes high one bit time after the last stop bit begins, if no character follows.
- R8: If the holding buffer is full and transmit is enabled when a frame ends, the next start bit follows the last stop bit directly, with no idle bit between the frames.
- R9: A load while `tx_rdy_o` is low is ignored: the buffered character is sent unchanged and nothing else is queued.
- R10: While `tx_en_i` is low, no frame starts and `tx_empty_o` stays high. A frame that was already under way when `tx_en_i` fell is sent to its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-rate clock enable pulse |
| rate_sel_i | input | 2 | Enable pulses per bit: 0→1, 1→16, 2/3→64 |
| char_i | input | CHAR_W | Character to send |
| load_i | input | 1 | Writes `char_i` into the holding buffer |
| len_sel_i | input | LEN_W | Data bits minus 5 |
| par_en_i | input | 1 | Adds a parity bit |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop_i | input | 1 | 1 selects two stop bits |
| tx_en_i | input | 1 | Lets new frames start |
| txd_o | output | 1 | Serial line |
| tx_rdy_o | output | 1 | Holding buffer is empty |
| tx_empty_o | output | 1 | Shift stage is idle |

## Verification
`tx_rdy_o` is due low one cycle after a load. The start bit, the rise of `tx_rdy_o` and the fall of `tx_empty_o` all share the first bit-boundary edge after the buffer fills. From then on, each bit lasts exactly F times the enable period in cycles, and `tx_empty_o` rises one bit time after the last stop bit begins. The bench drives and samples on falling edges. It anchors on the first falling-edge sample that shows the start bit low. It then steps by exactly one bit length per sample, so a wrong bit length, a missing or extra bit, or an idle gap between back-to-back frames shifts the samples and shows up as a mismatch.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int unsigned DIV_W = 6;

  // enable pulses per bit, minus one
  function automatic logic [DIV_W-1:0] div_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd0;
      2'd1:    return 6'd15;
      default: return 6'd63;
    endcase
  endfunction
endpackage

// File: rtl/sft_bit_timer.sv
module sft_bit_timer
  import sft_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic [1:0] rate_sel_i,
  output logic       tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;
  logic             wrap;

  assign lim    = div_limit(rate_sel_i);
  assign wrap   = (cnt_q >= lim);
  assign tick_o = bit_en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (bit_en_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/sft_hold_buf.sv
module sft_hold_buf #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         take_i,
  output logic [W-1:0] data_o,
  output logic         full_o
);
  logic         full_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end else if (load_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
endmodule

// File: rtl/sft_frame_shift.sv
module sft_frame_shift #(
  parameter int unsigned W       = 8,
  parameter int unsigned MIN_LEN = 5,
  parameter int unsigned LEN_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             avail_i,
  input  logic [W-1:0]     data_i,
  input  logic [LEN_W-1:0] len_sel_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic             two_stop_i,
  output logic             take_o,
  output logic             txd_o,
  output logic             busy_o
);
  localparam int unsigned FR_W  = W + 4;
  localparam int unsigned CNT_W = $clog2(FR_W + 1);

  logic [CNT_W-1:0] n_bits;
  logic [CNT_W-1:0] f_len;
  logic [W-1:0]     dmask;
  logic             par_bit;
  logic [FR_W-1:0]  frame;
  logic [FR_W-1:0]  sr_q;
  logic [CNT_W-1:0] left_q;
  logic             busy_q;
  logic             last;

  assign n_bits = CNT_W'(MIN_LEN) + CNT_W'(len_sel_i);

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign dmask[g] = (CNT_W'(g) < n_bits) ? data_i[g] : 1'b0;
  end

  assign par_bit = (^dmask) ^ par_odd_i;
  assign f_len   = n_bits + CNT_W'(2) + CNT_W'(par_en_i) + CNT_W'(two_stop_i);

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (CNT_W'(i) < n_bits) frame[i+1] = data_i[i];
    end
    if (par_en_i) frame[n_bits + 1'b1] = par_bit;
  end

  assign last   = busy_q && (left_q == CNT_W'(1));
  assign take_o = tick_i && avail_i && (!busy_q || last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (take_o) begin
      sr_q   <= frame;
      left_q <= f_len;
      busy_q <= 1'b1;
    end else if (tick_i && busy_q) begin
      if (last) begin
        sr_q   <= '1;
        left_q <= '0;
        busy_q <= 1'b0;
      end else begin
        sr_q   <= {1'b1, sr_q[FR_W-1:1]};
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign txd_o  = sr_q[0];
  assign busy_o = busy_q;
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter  int unsigned CHAR_W  = 8,
  parameter  int unsigned MIN_LEN = 5,
  localparam int unsigned LEN_W   = $clog2(CHAR_W - MIN_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic [1:0]        rate_sel_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              load_i,
  input  logic [LEN_W-1:0]  len_sel_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              tx_en_i,
  output logic              txd_o,
  output logic              tx_rdy_o,
  output logic              tx_empty_o
);
  logic              tick;
  logic              take;
  logic              full;
  logic              busy;
  logic [CHAR_W-1:0] held;

  sft_bit_timer u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (bit_en_i),
    .rate_sel_i (rate_sel_i),
    .tick_o     (tick)
  );

  sft_hold_buf #(.W(CHAR_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .data_i (char_i),
    .take_i (take),
    .data_o (held),
    .full_o (full)
  );

  sft_frame_shift #(.W(CHAR_W), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .avail_i    (full && tx_en_i),
    .data_i     (held),
    .len_sel_i  (len_sel_i),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .two_stop_i (two_stop_i),
    .take_o     (take),
    .txd_o      (txd_o),
    .busy_o     (busy)
  );

  assign tx_rdy_o   = !full;
  assign tx_empty_o = !busy;
endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic load_i,
  input logic tx_en_i,
  input logic txd_o,
  input logic tx_rdy_o,
  input logic tx_empty_o
);
  p_idle_line_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> txd_o);

  p_start_bit_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_empty_o) |-> !txd_o);

  p_line_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(txd_o));

  p_load_drops_rdy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_rdy_o && load_i) |=> !tx_rdy_o);

  p_rdy_rise_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_rdy_o) |-> !txd_o);

  p_no_start_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_o && !tx_en_i) |=> tx_empty_o);
endmodule

bind serial_frame_tx serial_frame_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_en_i   (bit_en_i),
  .load_i     (load_i),
  .tx_en_i    (tx_en_i),
  .txd_o      (txd_o),
  .tx_rdy_o   (tx_rdy_o),
  .tx_empty_o (tx_empty_o)
);

// File: tb/tb_serial_frame_tx.sv
module tb_serial_frame_tx;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en;
  logic [1:0] rate_sel = 2'd0;
  logic [7:0] char_in = 8'h00;
  logic       load = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       two_stop = 1'b0;
  logic       tx_en = 1'b1;
  logic       txd, tx_rdy, tx_empty;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int en_div = 1;
  int div_cnt = 0;
  int blen = 1;

  always #2.5 clk = ~clk;

  serial_frame_tx dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en), .rate_sel_i(rate_sel),
    .char_i(char_in), .load_i(load), .len_sel_i(len_sel), .par_en_i(par_en),
    .par_odd_i(par_odd), .two_stop_i(two_stop), .tx_en_i(tx_en),
    .txd_o(txd), .tx_rdy_o(tx_rdy), .tx_empty_o(tx_empty)
  );

  assign bit_en = (div_cnt == 0);

  always @(negedge clk) begin
    div_cnt <= (div_cnt + 1 >= en_div) ? 0 : div_cnt + 1;
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog all: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // {char[16:9], len[8:7], par_en[6], par_odd[5], two_stop[4], rate[3:2], div[1:0]}
  localparam logic [16:0] VEC [8] = '{
    {8'h47, 2'd3, 1'b0, 1'b0, 1'b1, 2'd0, 2'd1},
    {8'h49, 2'd3, 1'b1, 1'b0, 1'b0, 2'd1, 2'd1},
    {8'hA5, 2'd2, 1'b1, 1'b1, 1'b1, 2'd1, 2'd2},
    {8'h1F, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3},
    {8'hFF, 2'd1, 1'b1, 1'b1, 1'b0, 2'd0, 2'd1},
    {8'h3C, 2'd3, 1'b1, 1'b1, 1'b1, 2'd2, 2'd1},
    {8'h80, 2'd3, 1'b1, 1'b0, 1'b1, 2'd3, 2'd1},
    {8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd2}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int frame_len(input logic [7:0] c);
    int n = 5 + int'(len_sel);
    return 2 + n + int'(par_en) + int'(two_stop);
  endfunction

  function automatic logic [11:0] exp_frame(input logic [7:0] c);
    logic [11:0] f;
    int n = 5 + int'(len_sel);
    int ones = 0;
    for (int k = 0; k < n; k++) ones += int'(c[k]);
    for (int b = 0; b < 12; b++) begin
      if (b == 0) f[b] = 1'b0;
      else if (b <= n) f[b] = c[b-1];
      else if (par_en && b == n + 1) f[b] = par_odd ? ~ones[0] : ones[0];
      else f[b] = 1'b1;
    end
    return f;
  endfunction

  task automatic set_rate(input logic [1:0] r, input int d);
    rate_sel = r;
    en_div = d;
    blen = ((r == 2'd0) ? 1 : (r == 2'd1) ? 16 : 64) * d;
  endtask

  task automatic load_char(input logic [7:0] c);
    char_in = c;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_start();
    int t = 0;
    while (txd !== 1'b0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 5000) chk("R7 start timeout", 16'(txd), 16'h0);
  endtask

  // call at the first sample inside the start bit
  task automatic check_frame(input logic [7:0] c, input string tag);
    logic [11:0] got = '1;
    logic [11:0] exp = exp_frame(c);
    int len = frame_len(c);
    got[0] = txd;
    for (int i = 1; i < len; i++) begin
      repeat (blen) @(negedge clk);
      got[i] = txd;
    end
    chk(tag, 16'(got), 16'(exp));
  endtask

  initial begin
    set_rate(2'd0, 1);
    repeat (3) @(negedge clk);
    chk("R1 reset txd", 16'(txd), 16'h1);
    chk("R1 reset rdy", 16'(tx_rdy), 16'h1);
    chk("R1 reset empty", 16'(tx_empty), 16'h1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // table of frame formats and rates: R2 R3 R4 R5 R7
    for (int v = 0; v < 8; v++) begin
      char_in  = VEC[v][16:9];
      len_sel  = VEC[v][8:7];
      par_en   = VEC[v][6];
      par_odd  = VEC[v][5];
      two_stop = VEC[v][4];
      set_rate(VEC[v][3:2], int'(VEC[v][1:0]));
      repeat (4) @(negedge clk);
      load_char(VEC[v][16:9]);
      wait_start();
      check_frame(VEC[v][16:9], $sformatf("R2/R3/R4/R5 vector %0d", v));
      repeat (blen - 1) @(negedge clk);
      if (blen > 1) chk("R7 empty low in last stop", 16'(tx_empty), 16'h0);
      @(negedge clk);
      chk("R7 empty after frame", 16'(tx_empty), 16'h1);
    end

    // R6 R9 R10: disabled line holds, second load while full dropped
    len_sel = 2'd3; par_en = 1'b0; two_stop = 1'b0;
    set_rate(2'd0, 1);
    tx_en = 1'b0;
    load_char(8'h5A);
    chk("R6 rdy low after load", 16'(tx_rdy), 16'h0);
    load_char(8'hC3);
    repeat (200) @(negedge clk);
    chk("R10 no start while off", 16'(txd), 16'h1);
    chk("R10 empty while off", 16'(tx_empty), 16'h1);
    tx_en = 1'b1;
    wait_start();
    chk("R6 rdy rises with start", 16'(tx_rdy), 16'h1);
    check_frame(8'h5A, "R9 buffered char kept");
    repeat (blen) @(negedge clk);
    chk("R9 nothing queued", 16'(tx_empty), 16'h1);
    chk("R9 rdy after", 16'(tx_rdy), 16'h1);

    // R8 back-to-back frames at x16
    set_rate(2'd1, 1);
    par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b1;
    repeat (4) @(negedge clk);
    load_char(8'h96);
    wait_start();
    fork
      check_frame(8'h96, "R8 first frame");
      load_char(8'h2D);
    join
    repeat (blen) @(negedge clk);
    chk("R8 no idle gap", 16'(txd), 16'h0);
    chk("R8 empty stays low", 16'(tx_empty), 16'h0);
    check_frame(8'h2D, "R8 second frame");
    repeat (blen) @(negedge clk);
    chk("R7 empty after pair", 16'(tx_empty), 16'h1);

    // R10 enable drops mid-frame
    load_char(8'hE1);
    wait_start();
    fork
      check_frame(8'hE1, "R10 frame completes");
      begin
        load_char(8'h3B);
        repeat (3) @(negedge clk);
        tx_en = 1'b0;
      end
    join
    repeat (blen) @(negedge clk);
    chk("R10 idle after frame", 16'(tx_empty), 16'h1);
    repeat (3 * blen) @(negedge clk);
    chk("R10 line held high", 16'(txd), 16'h1);
    chk("R10 char still held", 16'(tx_rdy), 16'h0);
    tx_en = 1'b1;
    wait_start();
    check_frame(8'h3B, "R10 held char sent");
    repeat (blen + 2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule